// File: doc/BRIEF.md
# Enabled Adder/Subtractor with Overflow Status

This block is a purely combinational arithmetic function block of the kind used in industrial control logic. It adds or subtracts two operands of a parameterized width. It has an enable input and a status output. While the enable is high, the result output carries the wrapped result. The status output is then high only when the operation completed without overflow.

While the enable is low, the status output is held low and the result output is held at zero. A parameter fixes at build time whether the operands are treated as unsigned or as two's-complement numbers. The choice matters because the overflow rule differs between the two. A mode input selects addition or subtraction on every evaluation.

Top module: `enabled_adder`

## Requirements
- R1: While `en` is 0, `eno` is 0 for every value of `sub`, `a` and `b`.
- R2: While `en` is 0, `c` is all zeros for every value of `sub`, `a` and `b`.
- R3: While `en` is 1 and `sub` is 0, `c` equals `a + b` modulo 2^WIDTH. The same bit pattern results for both settings of `SIGNED`.
- R4: With `SIGNED` = 0, `en` = 1 and `sub` = 0, `eno` is 1 exactly when the unbounded sum `a + b` is below 2^WIDTH. For example, with a width of 8, 200 + 56 wraps to 0 and gives `eno` = 0.
- R5: While `en` is 1 and `sub` is 1, `c` equals `a - b` modulo 2^WIDTH. With `SIGNED` = 0, `eno` is 1 exactly when `a >= b`.
- R6: With `SIGNED` = 1, `en` = 1 and `sub` = 0, `eno` is 0 exactly when the true sum of the two's-complement operands lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. This happens when both operands have the same sign bit and bit WIDTH-1 of `c` differs from it.
- R7: With `SIGNED` = 1, `en` = 1 and `sub` = 1, `eno` is 0 exactly when the true difference `a - b` lies outside the two's-complement range. This happens when the operand sign bits differ and bit WIDTH-1 of `c` differs from the sign bit of `a`.
- R8: The range edges follow R4 to R7. For unsigned operands, all-ones + 0 and 0 - 0 set `eno` = 1. For signed operands, max + 1, min - 1 and min + min set `eno` = 0, while max + min and -1 - min set `eno` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Enable; 1 evaluates, 0 forces the idle outputs |
| sub | input | 1 | Operation select: 0 add, 1 subtract (a - b) |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| c | output | WIDTH | Wrapped result, zero while disabled |
| eno | output | 1 | High when enabled and no overflow occurred |

## Verification
The hardest situations to reach are the exact edges of the signed range. There, a result one step inside the range must pass and one step outside must fail. Uniform random operands rarely land on those edges. The stimulus therefore mixes random operands with a directed set built from the extreme values. That set includes max + 1, min - 1, min + min and max + min, and the matching unsigned all-ones and zero cases. Random operands are also biased toward values near the extremes, so that sign-bit combinations sit close to the overflow boundary. The same vectors drive an unsigned and a signed instance together.

// File: rtl/enabled_adder.sv
module enabled_adder #(
  parameter int WIDTH  = 8,
  parameter bit SIGNED = 1'b0
) (
  input  logic             en,
  input  logic             sub,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] c,
  output logic             eno
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] res;
  logic             ovf;

  assign res = sub ? (a - b) : (a + b);

  generate
    if (SIGNED) begin : g_signed
      logic sa, sb, sr, same_in;
      assign sa      = a[MSB];
      assign sb      = b[MSB];
      assign sr      = res[MSB];
      assign same_in = sub ? (sa != sb) : (sa == sb);
      assign ovf     = same_in && (sr != sa);
    end else begin : g_unsigned
      assign ovf = sub ? (a < b) : (res < a);
    end
  endgenerate

  assign c   = en ? res : '0;
  assign eno = en & ~ovf;
endmodule

// File: rtl/enabled_adder_chk.sv
module enabled_adder_chk #(
  parameter int WIDTH  = 8,
  parameter bit SIGNED = 1'b0
) (
  input logic             en,
  input logic             sub,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] c,
  input logic             eno
);
  logic signed [WIDTH:0] s_sum, s_dif;
  localparam logic signed [WIDTH:0] SMAX = (WIDTH+1)'((1 << (WIDTH-1)) - 1);
  localparam logic signed [WIDTH:0] SMIN = -SMAX - 1;

  assign s_sum = $signed({a[WIDTH-1], a}) + $signed({b[WIDTH-1], b});
  assign s_dif = $signed({a[WIDTH-1], a}) - $signed({b[WIDTH-1], b});

  always_comb begin
    if (!en) AST_IDLE_ENO: assert (!eno);                            // R1
    if (!en) AST_IDLE_ZERO: assert (c == '0);                        // R2
    if (en && !sub) AST_SUM_WRAP: assert (c == WIDTH'(a + b));       // R3
    if (en && sub) AST_DIFF_WRAP: assert (c == WIDTH'(a - b));       // R5
    if (!SIGNED && en && !sub) AST_UNS_CARRY: assert (eno == ({1'b0, a} + {1'b0, b} < (1 << WIDTH))); // R4
    if (!SIGNED && en && sub) AST_UNS_BORROW: assert (eno == (a >= b)); // R5
    if (SIGNED && en && !sub) AST_SGN_ADD: assert (eno == (s_sum <= SMAX && s_sum >= SMIN)); // R6
    if (SIGNED && en && sub) AST_SGN_SUB: assert (eno == (s_dif <= SMAX && s_dif >= SMIN));  // R7
  end
endmodule

bind enabled_adder enabled_adder_chk #(.WIDTH(WIDTH), .SIGNED(SIGNED)) u_chk (
  .en(en), .sub(sub), .a(a), .b(b), .c(c), .eno(eno)
);

// File: tb/test_enabled_adder.sv
`timescale 1ns/1ps
module test_enabled_adder;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         en, sub;
  logic [W-1:0] a, b;
  logic [W-1:0] c_u, c_s;
  logic         eno_u, eno_s;
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  enabled_adder #(.WIDTH(W), .SIGNED(1'b0)) i_enabled_adder (
    .en(en), .sub(sub), .a(a), .b(b), .c(c_u), .eno(eno_u));
  enabled_adder #(.WIDTH(W), .SIGNED(1'b1)) i_enabled_adder_sgn (
    .en(en), .sub(sub), .a(a), .b(b), .c(c_s), .eno(eno_s));

  function automatic logic [W-1:0] exp_c(bit e, bit s, logic [W-1:0] x, logic [W-1:0] y);
    if (!e) return '0;
    return s ? W'(x - y) : W'(x + y);
  endfunction

  function automatic bit exp_eno_u(bit e, bit s, logic [W-1:0] x, logic [W-1:0] y);
    int t = s ? int'(x) - int'(y) : int'(x) + int'(y);
    return e && t >= 0 && t <= (1 << W) - 1;
  endfunction

  function automatic bit exp_eno_s(bit e, bit s, logic [W-1:0] x, logic [W-1:0] y);
    int xs = int'($signed(x));
    int ys = int'($signed(y));
    int t = s ? xs - ys : xs + ys;
    return e && t >= -(1 << (W-1)) && t <= (1 << (W-1)) - 1;
  endfunction

  task automatic check1(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s a=%0d b=%0d en=%0b sub=%0b actual=%0d expected=%0d",
               tag, what, a, b, en, sub, act, exp);
    end
  endtask

  task automatic apply(string tag, bit e, bit s, logic [W-1:0] x, logic [W-1:0] y);
    string tc, tu, ts;
    @(posedge clk);
    #1;
    en = e; sub = s; a = x; b = y;
    @(negedge clk);
    if (tag != "") begin
      tc = tag; tu = tag; ts = tag;
    end else if (!e) begin
      tc = "R2"; tu = "R1"; ts = "R1";
    end else if (!s) begin
      tc = "R3"; tu = "R4"; ts = "R6";
    end else begin
      tc = "R5"; tu = "R5"; ts = "R7";
    end
    check1(tc, "c_unsigned", int'(c_u), int'(exp_c(e, s, x, y)));
    check1(tc, "c_signed",   int'(c_s), int'(exp_c(e, s, x, y)));
    check1(tu, "eno_unsigned", int'(eno_u), int'(exp_eno_u(e, s, x, y)));
    check1(ts, "eno_signed",   int'(eno_s), int'(exp_eno_s(e, s, x, y)));
  endtask

  function automatic logic [W-1:0] pick(int r);
    case (r % 4)
      0: return W'($urandom);
      1: return W'(8'h7f - ($urandom % 3) + 1);
      2: return W'(8'h80 + ($urandom % 3) - 1);
      default: return W'(($urandom % 3) - 1);
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    en = 0; sub = 0; a = '0; b = '0;
    // reset state: disabled outputs, R1 and R2
    apply("R1", 0, 0, 8'd0, 8'd0);
    apply("R2", 0, 1, 8'hff, 8'h01);
    apply("R2", 0, 0, 8'hc8, 8'h38);
    // R4: wrap to zero counts as overflow
    apply("R4", 1, 0, 8'd200, 8'd56);
    apply("R3", 1, 0, 8'd21, 8'd11);
    // R8 edges
    apply("R8", 1, 0, 8'hff, 8'h00);
    apply("R8", 1, 1, 8'h00, 8'h00);
    apply("R8", 1, 0, 8'h7f, 8'h01);
    apply("R8", 1, 1, 8'h80, 8'h01);
    apply("R8", 1, 0, 8'h80, 8'h80);
    apply("R8", 1, 0, 8'h7f, 8'h80);
    apply("R8", 1, 1, 8'hff, 8'h80);
    apply("R8", 1, 1, 8'h00, 8'h80);
    apply("R5", 1, 1, 8'd3, 8'd5);
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x, y;
      x = pick(int'($urandom));
      y = pick(int'($urandom));
      apply("", ($urandom % 5) != 0, $urandom % 2 == 1, x, y);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule